// File: doc/BRIEF.md
# Self-Clearing Software Reset Controller

This block holds one 32-bit control word. Software sets bits in it to reset four separate domains: the main digital core, two PHY ports and a virtual PHY. A bit that is set drives its domain's reset output. The bit stays set for a hardware-timed hold window and then clears itself, so software learns that the domain is out of reset by polling the bit.

The PHY port resets are held for a minimum width derived from the clock frequency (102 µs worth of cycles). The virtual PHY and core resets are held for a shorter parameterised window.

Asserting the core reset sends a one-cycle abort to the configuration loader. Releasing the core reset sends that loader a one-cycle reload request. The loader's own write path can never set any of the four bits. The register stays readable at all times, including while any domain is held in reset.

Top module: `swrst_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni`, all four reset outputs, `ld_reload_o` and `ld_abort_o` are 0, and a read of the control word returns 0.
- R2: A read (`req_i`=1, `we_i`=0) at address `CTL_ADDR` returns the live bits in the same cycle: bit 0 is core, bit 1 is PHY port 1, bit 2 is PHY port 2 and bit 3 is the virtual PHY. Bits 31:4 read as 0. Any other address, and any cycle without a read, returns 0.
- R3: A bus write at `CTL_ADDR` with data bit d = 1 sets bit d on that clock edge, and the matching reset output is 1 from the next cycle. Data bits that are 0, the reserved bits, and writes to any other address have no effect.
- R4: A PHY port bit (bit 1 or bit 2) stays 1 for exactly `PHY_HOLD_CYC` cycles and then clears itself. The default is `CLK_MHZ`×102.
- R5: The core bit and the virtual PHY bit each stay 1 for exactly `AUX_HOLD_CYC` cycles and then clear themselves.
- R6: A write of 1 to a bit that is already set is ignored; it does not restart or extend that bit's hold window.
- R7: Setting the core bit (bit 0) never asserts the PHY port or virtual PHY reset outputs.
- R8: `ld_reload_o` is 1 for exactly one cycle: the first cycle in which the core bit reads 0 after a core reset.
- R9: `ld_abort_o` is 1 for exactly one cycle: the first cycle in which the core bit is 1.
- R10: Loader writes (`ld_we_i`) never set any bit, even with all four data bits at 1 and the address equal to `CTL_ADDR`.
- R11: Bits set in one write, or in different cycles, each time out on their own schedule without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | DATA_W | Bus write data |
| rdata_o | output | DATA_W | Bus read data, combinational |
| ld_we_i | input | 1 | Configuration loader write strobe |
| ld_addr_i | input | ADDR_W | Loader write address |
| ld_wdata_i | input | DATA_W | Loader write data |
| core_rst_o | output | 1 | Digital core reset |
| phy1_rst_o | output | 1 | PHY port 1 reset |
| phy2_rst_o | output | 1 | PHY port 2 reset |
| vphy_rst_o | output | 1 | Virtual PHY reset |
| ld_reload_o | output | 1 | Configuration reload request, one cycle |
| ld_abort_o | output | 1 | Abort of the loader's current command, one cycle |

## Verification
The hardest situation to reach from the ports is a write that lands on a bit in the middle of its hold window while other bits start or end in nearby cycles. That is where an ignored write could wrongly restart a counter, or one channel could disturb another. The stimulus writes all four bits together. While they are pending, it re-writes them and writes a staggered mask, so the short and long windows overlap and end in different cycles. A behavioural model predicts every output on every clock, and the measured high widths of each reset output are compared against the hold parameters.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int N_DOM = 4;

  // Bit positions inside the control word
  typedef enum int {
    DOM_CORE = 0,
    DOM_PHY1 = 1,
    DOM_PHY2 = 2,
    DOM_VPHY = 3
  } dom_e;

  // Loader path may set none of the reset bits
  localparam logic [N_DOM-1:0] LD_SET_MASK = '0;

  function automatic bit is_phy(int d);
    return (d == DOM_PHY1) || (d == DOM_PHY2);
  endfunction
endpackage

// File: rtl/swrst_bus_dec.sv
module swrst_bus_dec
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h40
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_wdata_i,
  output logic [N_DOM-1:0]  set_req_o,
  output logic              rd_hit_o
);
  logic bus_hit;
  logic ld_hit;
  logic unused_rsvd;

  assign bus_hit  = req_i && (addr_i == CTL_ADDR);
  assign ld_hit   = ld_we_i && (ld_addr_i == CTL_ADDR);
  assign rd_hit_o = bus_hit && !we_i;

  always_comb begin
    set_req_o = '0;
    if (bus_hit && we_i) set_req_o = wdata_i[N_DOM-1:0];
    if (ld_hit) set_req_o = set_req_o | (ld_wdata_i[N_DOM-1:0] & LD_SET_MASK);
  end

  assign unused_rsvd = ^{wdata_i[DATA_W-1:N_DOM], ld_wdata_i[DATA_W-1:N_DOM]};
endmodule

// File: rtl/swrst_hold_chan.sv
module swrst_hold_chan #(
  parameter int HOLD = 16,
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic accept_o,
  output logic done_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;

  // a start while active is dropped
  assign accept_o = start_i && !active_q;
  assign done_o   = active_q && (cnt_q == CW'(HOLD - 1));
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (done_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h40,
  parameter int CLK_MHZ = 250,
  parameter int PHY_MIN_US = 102,
  parameter int PHY_HOLD_CYC = CLK_MHZ * PHY_MIN_US,
  parameter int AUX_HOLD_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_wdata_i,
  output logic              core_rst_o,
  output logic              phy1_rst_o,
  output logic              phy2_rst_o,
  output logic              vphy_rst_o,
  output logic              ld_reload_o,
  output logic              ld_abort_o
);
  logic [N_DOM-1:0] set_req;
  logic [N_DOM-1:0] dom_act;
  logic [N_DOM-1:0] dom_acc;
  logic [N_DOM-1:0] dom_done;
  logic             rd_hit;
  logic             reload_q;
  logic             abort_q;

  swrst_bus_dec #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTL_ADDR(CTL_ADDR)
  ) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ld_we_i   (ld_we_i),
    .ld_addr_i (ld_addr_i),
    .ld_wdata_i(ld_wdata_i),
    .set_req_o (set_req),
    .rd_hit_o  (rd_hit)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_chan
    localparam int HOLD = is_phy(d) ? PHY_HOLD_CYC : AUX_HOLD_CYC;
    swrst_hold_chan #(.HOLD(HOLD)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (set_req[d]),
      .active_o(dom_act[d]),
      .accept_o(dom_acc[d]),
      .done_o  (dom_done[d])
    );
  end

  // loader handshakes follow the core channel edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      reload_q <= dom_done[DOM_CORE];
      abort_q  <= dom_acc[DOM_CORE];
    end
  end

  assign rdata_o     = rd_hit ? DATA_W'(dom_act) : '0;
  assign core_rst_o  = dom_act[DOM_CORE];
  assign phy1_rst_o  = dom_act[DOM_PHY1];
  assign phy2_rst_o  = dom_act[DOM_PHY2];
  assign vphy_rst_o  = dom_act[DOM_VPHY];
  assign ld_reload_o = reload_q;
  assign ld_abort_o  = abort_q;
endmodule

// File: rtl/swrst_ctrl_chk.sv
module swrst_ctrl_chk
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h40,
  parameter int PHY_HOLD_CYC = 16,
  parameter int AUX_HOLD_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              core_rst_o,
  input logic              phy1_rst_o,
  input logic              phy2_rst_o,
  input logic              vphy_rst_o,
  input logic              ld_reload_o,
  input logic              ld_abort_o
);
  logic [N_DOM-1:0] dom;
  logic             wr_hit;
  assign dom    = {vphy_rst_o, phy2_rst_o, phy1_rst_o, core_rst_o};
  assign wr_hit = req_i && we_i && (addr_i == CTL_ADDR);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:N_DOM] == '0);

  p_reload_on_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> ld_reload_o);
  p_reload_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_reload_o |=> !ld_reload_o);

  p_abort_on_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> ld_abort_o);
  p_abort_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_abort_o |-> core_rst_o);

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    localparam int HOLD = is_phy(d) ? PHY_HOLD_CYC : AUX_HOLD_CYC;
    logic [31:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= '0;
      else         run_q <= dom[d] ? run_q + 1 : '0;
    end

    // rises only from a bus write of its own bit (R7, R10)
    p_rise_by_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dom[d]) |-> $past(wr_hit && wdata_i[d]));

    if (is_phy(d)) begin : g_phy
      p_phy_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dom[d]) |-> run_q == 32'(HOLD));
      p_phy_no_extend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dom[d] |-> run_q < 32'(HOLD));
    end else begin : g_aux
      p_aux_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dom[d]) |-> run_q == 32'(HOLD));
      p_aux_no_extend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dom[d] |-> run_q < 32'(HOLD));
    end
  end
endmodule

bind swrst_ctrl swrst_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CTL_ADDR    (CTL_ADDR),
  .PHY_HOLD_CYC(PHY_HOLD_CYC),
  .AUX_HOLD_CYC(AUX_HOLD_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .core_rst_o (core_rst_o),
  .phy1_rst_o (phy1_rst_o),
  .phy2_rst_o (phy2_rst_o),
  .vphy_rst_o (vphy_rst_o),
  .ld_reload_o(ld_reload_o),
  .ld_abort_o (ld_abort_o)
);

// File: tb/test_swrst_ctrl.sv
`timescale 1ns/1ps
module test_swrst_ctrl;
  localparam int PHY_H = 40;
  localparam int AUX_H = 8;
  localparam logic [7:0] CTL = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_wdata = '0;
  logic        core_rst, phy1_rst, phy2_rst, vphy_rst, reload, abort_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swrst_ctrl #(
    .CTL_ADDR    (CTL),
    .PHY_HOLD_CYC(PHY_H),
    .AUX_HOLD_CYC(AUX_H)
  ) i_swrst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ld_we_i(ld_we), .ld_addr_i(ld_addr),
    .ld_wdata_i(ld_wdata), .core_rst_o(core_rst), .phy1_rst_o(phy1_rst),
    .phy2_rst_o(phy2_rst), .vphy_rst_o(vphy_rst), .ld_reload_o(reload),
    .ld_abort_o(abort_o)
  );

  // behavioural reference: remaining hold cycles per bit
  int  rem [4];
  bit  m_reload, m_abort;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (rem[i]) rem[i] = 0;
      m_reload = 0;
      m_abort  = 0;
    end else begin
      m_reload = 0;
      m_abort  = 0;
      for (int d = 0; d < 4; d++) begin
        if (rem[d] > 0) begin
          rem[d]--;
          if (rem[d] == 0 && d == 0) m_reload = 1;
        end else if (req && we && addr == CTL && wdata[d]) begin
          rem[d] = (d == 1 || d == 2) ? PHY_H : AUX_H;
          if (d == 0) m_abort = 1;
        end
      end
    end
  end

  function automatic logic [3:0] m_bits();
    logic [3:0] b;
    for (int d = 0; d < 4; d++) b[d] = rem[d] > 0;
    return b;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // measured high widths and reload count
  int run_w [4];
  int last_w [4];
  int reload_cnt = 0;
  int abort_cnt = 0;

  always @(negedge clk) begin
    logic [3:0] eb, ab;
    logic [31:0] er;
    if (rst_n && !done) begin
      eb = m_bits();
      ab = {vphy_rst, phy2_rst, phy1_rst, core_rst};
      er = (req && !we && addr == CTL) ? {28'b0, eb} : 32'b0;
      chk(rdata == er, "R2 rdata", rdata, er);
      chk(ab[0] == eb[0], "R5 core_rst", ab[0], eb[0]);
      chk(ab[1] == eb[1], "R4 phy1_rst", ab[1], eb[1]);
      chk(ab[2] == eb[2], "R4 phy2_rst", ab[2], eb[2]);
      chk(ab[3] == eb[3], "R11 vphy_rst", ab[3], eb[3]);
      chk(reload == m_reload, "R8 reload", reload, m_reload);
      chk(abort_o == m_abort, "R9 abort", abort_o, m_abort);
      for (int d = 0; d < 4; d++) begin
        if (ab[d]) run_w[d]++;
        else if (run_w[d] > 0) begin
          last_w[d] = run_w[d];
          run_w[d] = 0;
        end
      end
      if (reload) reload_cnt++;
      if (abort_o) abort_cnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    cyc(1);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    req = 1; we = 0; addr = a;
    cyc(1);
    req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    #1;
    rst_n = 1;
    // R1: reset state
    #1;
    chk({vphy_rst, phy2_rst, phy1_rst, core_rst, reload, abort_o} == 6'b0,
        "R1 outputs", {vphy_rst, phy2_rst, phy1_rst, core_rst}, 0);
    cyc(1);
    bus_rd(CTL);
    bus_rd(8'h44);
    // R3/R4: phy1 alone, poll, then re-write (R6)
    bus_wr(CTL, 32'h2);
    bus_rd(CTL);
    cyc(10);
    bus_wr(CTL, 32'h2);
    cyc(PHY_H);
    chk(last_w[1] == PHY_H, "R4 phy1 width", last_w[1], PHY_H);
    chk(last_w[1] == PHY_H, "R6 no restart", last_w[1], PHY_H);
    // R7/R8/R9: core reset alone
    bus_wr(CTL, 32'h1);
    for (int i = 0; i < AUX_H + 2; i++) begin
      chk({vphy_rst, phy2_rst, phy1_rst} == 3'b0, "R7 others quiet",
          {vphy_rst, phy2_rst, phy1_rst}, 0);
      bus_rd(CTL);
    end
    chk(last_w[0] == AUX_H, "R5 core width", last_w[0], AUX_H);
    chk(reload_cnt == 1, "R8 reload count", reload_cnt, 1);
    chk(abort_cnt == 1, "R9 abort count", abort_cnt, 1);
    // R11: all bits, staggered re-writes
    bus_wr(CTL, 32'hF);
    cyc(3);
    bus_wr(CTL, 32'h9);
    cyc(AUX_H);
    bus_wr(CTL, 32'h9);
    bus_rd(CTL);
    cyc(PHY_H);
    chk(last_w[2] == PHY_H, "R11 phy2 width", last_w[2], PHY_H);
    chk(last_w[3] == AUX_H, "R5 vphy width", last_w[3], AUX_H);
    chk(reload_cnt == 3, "R8 reload count", reload_cnt, 3);
    // R10: loader writes every bit at the control address
    ld_we = 1; ld_addr = CTL; ld_wdata = 32'hFFFF_FFFF;
    cyc(2);
    ld_we = 0;
    chk({vphy_rst, phy2_rst, phy1_rst, core_rst} == 4'b0, "R10 loader",
        {vphy_rst, phy2_rst, phy1_rst, core_rst}, 0);
    // R3: other address and reserved bits have no effect
    bus_wr(8'h44, 32'hF);
    bus_wr(CTL, 32'hFFFF_FFF0);
    chk({vphy_rst, phy2_rst, phy1_rst, core_rst} == 4'b0, "R3 no-op writes",
        {vphy_rst, phy2_rst, phy1_rst, core_rst}, 0);
    bus_rd(CTL);
    cyc(4);
    finish_run();
  end
endmodule